// File: doc/BRIEF.md
# Interrupt Priority Selector with Recall

This block keeps the state of a small set of interrupt sources (32 by default): pending, active, individual enable, a group bit, a trigger mode and a priority value. Every cycle it finds the best candidate among the enabled, pending, not-active sources and registers it on a single forwarding port toward a CPU interface. Each source can be configured as level or edge triggered.

Software-side configuration uses a single-cycle write port. That port carries enables, group bits, trigger modes, priorities and the two group enables. The CPU side acknowledges the forwarded interrupt, which moves it from pending to active and returns its ID. An end-of-interrupt with an ID retires the active instance. The priority of each active instance is captured at acknowledge. The lowest of these captured priorities is the running priority, and only candidates strictly more urgent than the running priority are forwarded. If the priority of the forwarded interrupt is rewritten while it is still pending and not taken, the block withdraws it with a one-cycle recall pulse and then selects again.

Top module: `irq_prio_sel`

## Requirements
- R1: After reset, nothing is forwarded and the acknowledge ID reads 63. The running priority reads 32 (idle) and no recall is raised. All enables and group enables are cleared, and sources are level triggered.
- R2: The forwarded interrupt has the numerically smallest priority among eligible sources. It appears with its ID and priority on the forwarding port two clock edges after its pending input is asserted.
- R3: When priorities tie, the lowest interrupt ID is forwarded.
- R4: A source is left out of selection if its individual enable is clear, or if the enable of its group (bit 0 for group 0, bit 1 for group 1 in the group-enable write) is clear. Such a source never keeps a less urgent eligible source from being forwarded.
- R5: Pending is set whatever the enable and group-enable settings are. A level source (trigger bit 0) re-pends on every cycle its input is high. An edge source (trigger bit 1) pends once per rising edge.
- R6: An acknowledge while an interrupt is forwarded returns that ID on ack_id_o in the same cycle and marks the interrupt active. The forwarding port is then empty on the following cycle.
- R7: An active interrupt is not forwarded again until its end-of-interrupt, even when it is set pending again.
- R8: End-of-interrupt clears the active bit of the given ID, so the running priority is recomputed and a re-pended instance can be forwarded.
- R9: The running priority is the lowest priority captured by any active interrupt, or 32 when none is active. Only candidates whose priority is strictly below the running priority are forwarded.
- R10: A priority write to the currently forwarded interrupt raises recall_o for one cycle with its ID. The forwarding port is cleared, and selection then runs again with the new value.
- R11: A priority write to an active interrupt leaves its running priority unchanged and raises no recall. The new value applies to its next instance.
- R12: Sources with ID 24 and above use 16 levels: bit 0 of any priority written to them is forced to zero.
- R13: An acknowledge while nothing is forwarded returns the spurious ID 63 and changes no state.
- R14: When an acknowledge and a priority rewrite of the forwarded interrupt fall in the same cycle, the acknowledge wins. No recall is raised, and the active instance keeps the old priority.

Write-port field select (reg_sel_i): 0 enable (wdata bit 0), 1 group (wdata bit 0), 2 priority (wdata), 3 trigger (wdata bit 0), 4 group enables (wdata bits 1:0, ID ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_IRQ | Per-source interrupt request inputs |
| reg_we_i | input | 1 | Configuration write strobe |
| reg_sel_i | input | 3 | Field select for the write |
| reg_id_i | input | ID_W | Target interrupt ID of the write |
| reg_wdata_i | input | PRIO_W | Write data |
| ack_i | input | 1 | Acknowledge from CPU side |
| ack_id_o | output | ID_W | ID returned for an acknowledge (63 when spurious) |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_id_i | input | ID_W | ID being retired |
| fwd_valid_o | output | 1 | An interrupt is forwarded |
| fwd_id_o | output | ID_W | Forwarded interrupt ID |
| fwd_prio_o | output | PRIO_W | Forwarded interrupt priority |
| running_prio_o | output | PRIO_W+1 | Lowest priority among active interrupts, 32 when idle |
| recall_o | output | 1 | One-cycle withdrawal pulse |
| recall_id_o | output | ID_W | ID withdrawn by the last recall |

## Verification
The collision of interest is an acknowledge and a priority rewrite of the same forwarded interrupt landing in the same cycle. Both events target the same forwarding register: one would mark the interrupt taken, the other would withdraw it. The bench drives both strobes on the same clock edge. It judges the outcome by three observations at the ports: the returned ID, the absence of any recall pulse, and a running priority that still carries the priority in force before the rewrite.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [2:0] {
    SEL_ENABLE = 3'd0,
    SEL_GROUP  = 3'd1,
    SEL_PRIO   = 3'd2,
    SEL_TRIG   = 3'd3,
    SEL_GRPEN  = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/irq_state_bank.sv
module irq_state_bank
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ  = 32,
  parameter int PRIO_W   = 5,
  parameter int ID_W     = 6,
  parameter int NS_FIRST = 24
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_IRQ-1:0]             src_i,
  input  logic                           reg_we_i,
  input  reg_sel_e                       reg_sel_i,
  input  logic [ID_W-1:0]                reg_id_i,
  input  logic [PRIO_W-1:0]              reg_wdata_i,
  input  logic                           take_i,
  input  logic [ID_W-1:0]                take_id_i,
  input  logic                           eoi_i,
  input  logic [ID_W-1:0]                eoi_id_i,
  output logic [NUM_IRQ-1:0]             pend_o,
  output logic [NUM_IRQ-1:0]             en_o,
  output logic [NUM_IRQ-1:0]             grp_o,
  output logic [NUM_IRQ-1:0]             act_o,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_o,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0] act_prio_o,
  output logic [1:0]                     grp_en_o
);

  logic [NUM_IRQ-1:0] src_q;
  logic [NUM_IRQ-1:0] trig_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q    <= '0;
      grp_en_o <= '0;
    end else begin
      src_q <= src_i;
      if (reg_we_i && reg_sel_i == SEL_GRPEN) grp_en_o <= reg_wdata_i[1:0];
    end
  end

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
    // coarse class keeps only the upper priority bits
    localparam logic [PRIO_W-1:0] PMASK =
      (i >= NS_FIRST) ? {{(PRIO_W-1){1'b1}}, 1'b0} : {PRIO_W{1'b1}};

    logic hit, set_p, take_me, eoi_me;

    assign hit     = reg_we_i && (reg_id_i == ID_W'(i));
    assign set_p   = trig_edge[i] ? (src_i[i] & ~src_q[i]) : src_i[i];
    assign take_me = take_i && (take_id_i == ID_W'(i));
    assign eoi_me  = eoi_i && (eoi_id_i == ID_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[i]       <= 1'b0;
        grp_o[i]      <= 1'b0;
        trig_edge[i]  <= 1'b0;
        prio_o[i]     <= PMASK;
        pend_o[i]     <= 1'b0;
        act_o[i]      <= 1'b0;
        act_prio_o[i] <= '1;
      end else begin
        if (hit && reg_sel_i == SEL_ENABLE) en_o[i]      <= reg_wdata_i[0];
        if (hit && reg_sel_i == SEL_GROUP)  grp_o[i]     <= reg_wdata_i[0];
        if (hit && reg_sel_i == SEL_TRIG)   trig_edge[i] <= reg_wdata_i[0];
        if (hit && reg_sel_i == SEL_PRIO)   prio_o[i]    <= reg_wdata_i & PMASK;
        // a new request wins over the clear from acknowledge
        pend_o[i] <= set_p | (pend_o[i] & ~take_me);
        act_o[i]  <= take_me | (act_o[i] & ~eoi_me);
        if (take_me) act_prio_o[i] <= prio_o[i];
      end
    end

    // R12
    ns_lsb_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (i >= NS_FIRST) |-> !prio_o[i][0]);
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_IRQ = 32,
  parameter int PRIO_W  = 5,
  parameter int ID_W    = 6
) (
  input  logic [NUM_IRQ-1:0]             pend_i,
  input  logic [NUM_IRQ-1:0]             en_i,
  input  logic [NUM_IRQ-1:0]             grp_i,
  input  logic [NUM_IRQ-1:0]             act_i,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_i,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0] act_prio_i,
  input  logic [1:0]                     grp_en_i,
  output logic                           best_valid_o,
  output logic [ID_W-1:0]                best_id_o,
  output logic [PRIO_W-1:0]              best_prio_o,
  output logic [PRIO_W:0]                run_prio_o
);

  localparam logic [PRIO_W:0] RUN_IDLE = {1'b1, {PRIO_W{1'b0}}};

  always_comb begin
    run_prio_o = RUN_IDLE;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (act_i[i] && ({1'b0, act_prio_i[i]} < run_prio_o))
        run_prio_o = {1'b0, act_prio_i[i]};
    end
  end

  always_comb begin
    logic elig;
    best_valid_o = 1'b0;
    best_id_o    = '0;
    best_prio_o  = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      elig = pend_i[i] & en_i[i] & grp_en_i[grp_i[i]] & ~act_i[i]
           & ({1'b0, prio_i[i]} < run_prio_o);
      // strict compare keeps the lowest ID on a tie
      if (elig && (!best_valid_o || prio_i[i] < best_prio_o)) begin
        best_valid_o = 1'b1;
        best_id_o    = ID_W'(i);
        best_prio_o  = prio_i[i];
      end
    end
  end

endmodule

// File: rtl/irq_fwd_ctrl.sv
module irq_fwd_ctrl #(
  parameter int PRIO_W = 5,
  parameter int ID_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              best_valid_i,
  input  logic [ID_W-1:0]   best_id_i,
  input  logic [PRIO_W-1:0] best_prio_i,
  input  logic              ack_i,
  input  logic              prio_wr_i,
  input  logic [ID_W-1:0]   wr_id_i,
  output logic              take_o,
  output logic [ID_W-1:0]   ack_id_o,
  output logic              fwd_valid_o,
  output logic [ID_W-1:0]   fwd_id_o,
  output logic [PRIO_W-1:0] fwd_prio_o,
  output logic              recall_o,
  output logic [ID_W-1:0]   recall_id_o
);

  logic withdraw;

  assign take_o   = ack_i && fwd_valid_o;
  assign ack_id_o = fwd_valid_o ? fwd_id_o : '1;
  // an acknowledge in the same cycle takes the interrupt instead
  assign withdraw = prio_wr_i && fwd_valid_o && (wr_id_i == fwd_id_o) && !ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o <= 1'b0;
      fwd_id_o    <= '0;
      fwd_prio_o  <= '0;
      recall_o    <= 1'b0;
      recall_id_o <= '0;
    end else begin
      recall_o <= withdraw;
      if (withdraw) recall_id_o <= fwd_id_o;
      fwd_valid_o <= (take_o || withdraw) ? 1'b0 : best_valid_i;
      fwd_id_o    <= best_id_i;
      fwd_prio_o  <= best_prio_i;
    end
  end

  // R10
  recall_clears_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |-> !fwd_valid_o);

  // R6
  ack_empties_fwd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && fwd_valid_o) |=> !fwd_valid_o);

  // R10
  recall_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_o |=> !recall_o);

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_sel_pkg::*;
#(
  parameter int NUM_IRQ  = 32,
  parameter int PRIO_W   = 5,
  parameter int NS_FIRST = 24,
  localparam int ID_W    = $clog2(NUM_IRQ + 1),
  localparam int IDX_W   = $clog2(NUM_IRQ)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] src_i,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_sel_i,
  input  logic [ID_W-1:0]    reg_id_i,
  input  logic [PRIO_W-1:0]  reg_wdata_i,
  input  logic               ack_i,
  output logic [ID_W-1:0]    ack_id_o,
  input  logic               eoi_i,
  input  logic [ID_W-1:0]    eoi_id_i,
  output logic               fwd_valid_o,
  output logic [ID_W-1:0]    fwd_id_o,
  output logic [PRIO_W-1:0]  fwd_prio_o,
  output logic [PRIO_W:0]    running_prio_o,
  output logic               recall_o,
  output logic [ID_W-1:0]    recall_id_o
);

  reg_sel_e                       sel;
  logic [NUM_IRQ-1:0]             pend, en, grp, act;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio, act_prio;
  logic [1:0]                     grp_en;
  logic                           best_valid, take;
  logic [ID_W-1:0]                best_id;
  logic [PRIO_W-1:0]              best_prio;

  assign sel = reg_sel_e'(reg_sel_i);

  irq_state_bank #(
    .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W), .NS_FIRST(NS_FIRST)
  ) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src_i),
    .reg_we_i   (reg_we_i),
    .reg_sel_i  (sel),
    .reg_id_i   (reg_id_i),
    .reg_wdata_i(reg_wdata_i),
    .take_i     (take),
    .take_id_i  (fwd_id_o),
    .eoi_i      (eoi_i),
    .eoi_id_i   (eoi_id_i),
    .pend_o     (pend),
    .en_o       (en),
    .grp_o      (grp),
    .act_o      (act),
    .prio_o     (prio),
    .act_prio_o (act_prio),
    .grp_en_o   (grp_en)
  );

  irq_prio_pick #(
    .NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) u_pick (
    .pend_i      (pend),
    .en_i        (en),
    .grp_i       (grp),
    .act_i       (act),
    .prio_i      (prio),
    .act_prio_i  (act_prio),
    .grp_en_i    (grp_en),
    .best_valid_o(best_valid),
    .best_id_o   (best_id),
    .best_prio_o (best_prio),
    .run_prio_o  (running_prio_o)
  );

  irq_fwd_ctrl #(
    .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) u_fwd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .best_valid_i(best_valid),
    .best_id_i   (best_id),
    .best_prio_i (best_prio),
    .ack_i       (ack_i),
    .prio_wr_i   (reg_we_i && sel == SEL_PRIO),
    .wr_id_i     (reg_id_i),
    .take_o      (take),
    .ack_id_o    (ack_id_o),
    .fwd_valid_o (fwd_valid_o),
    .fwd_id_o    (fwd_id_o),
    .fwd_prio_o  (fwd_prio_o),
    .recall_o    (recall_o),
    .recall_id_o (recall_id_o)
  );

  // R7
  fwd_not_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> !act[IDX_W'(fwd_id_o)]);

  // R9
  fwd_beats_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> ({1'b0, fwd_prio_o} < running_prio_o));

  // R13
  spurious_ack_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !fwd_valid_o) |=> $stable(act));

endmodule

// File: tb/irq_prio_sel_test.sv
module irq_prio_sel_test;
  import irq_sel_pkg::*;

  localparam int N    = 32;
  localparam int PW   = 5;
  localparam int IW   = 6;
  localparam int SPUR = 63;
  localparam int IDLE = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic          reg_we_i = 1'b0;
  logic [2:0]    reg_sel_i = '0;
  logic [IW-1:0] reg_id_i = '0;
  logic [PW-1:0] reg_wdata_i = '0;
  logic          ack_i = 1'b0;
  logic [IW-1:0] ack_id_o;
  logic          eoi_i = 1'b0;
  logic [IW-1:0] eoi_id_i = '0;
  logic          fwd_valid_o;
  logic [IW-1:0] fwd_id_o;
  logic [PW-1:0] fwd_prio_o;
  logic [PW:0]   running_prio_o;
  logic          recall_o;
  logic [IW-1:0] recall_id_o;

  int n_vec = 0;
  int n_bad = 0;
  int rec_cnt = 0;
  int rec_last = -1;
  int ack_exp_q[$];
  int ack_act_q[$];
  string ack_tag_q[$];

  always #10ns clk_i = ~clk_i;

  irq_prio_sel uut (.*);

  task automatic chk(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares acknowledge results as they are produced
  initial forever begin
    @(negedge clk_i);
    while (ack_act_q.size() > 0) begin
      chk(ack_tag_q.pop_front(), ack_act_q.pop_front(), ack_exp_q.pop_front());
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && recall_o) begin
      rec_cnt++;
      rec_last = int'(recall_id_o);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; src_i = '0; reg_we_i = 1'b0; ack_i = 1'b0; eoi_i = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    rec_cnt = 0;
    rec_last = -1;
  endtask

  task automatic wr(reg_sel_e s, int id, int d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = s; reg_id_i = IW'(id); reg_wdata_i = PW'(d);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic cfg(int id, int p);
    wr(SEL_PRIO, id, p);
    wr(SEL_ENABLE, id, 1);
  endtask

  task automatic ack_exp(int exp, string tag);
    @(negedge clk_i);
    ack_i = 1'b1;
    #1ns;
    ack_exp_q.push_back(exp);
    ack_tag_q.push_back(tag);
    ack_act_q.push_back(int'(ack_id_o));
    @(negedge clk_i);
    ack_i = 1'b0;
  endtask

  task automatic eoi(int id);
    @(negedge clk_i);
    eoi_i = 1'b1; eoi_id_i = IW'(id);
    @(negedge clk_i);
    eoi_i = 1'b0;
  endtask

  task automatic fwd_is(string tag, int id, int p);
    chk({tag, " valid"}, int'(fwd_valid_o), 1);
    chk({tag, " id"}, int'(fwd_id_o), id);
    chk({tag, " prio"}, int'(fwd_prio_o), p);
  endtask

  initial begin
    #4ms;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    idle(2);
    // R1 reset state
    chk("R1 fwd_valid", int'(fwd_valid_o), 0);
    chk("R1 ack_id", int'(ack_id_o), SPUR);
    chk("R1 running", int'(running_prio_o), IDLE);
    chk("R1 recall", int'(recall_o), 0);
    do_reset();

    // R2 / R3 selection and tie
    wr(SEL_GRPEN, 0, 3);
    cfg(3, 10); cfg(5, 4); cfg(9, 4);
    @(negedge clk_i); src_i[3] = 1'b1; src_i[5] = 1'b1; src_i[9] = 1'b1;
    idle(2);
    fwd_is("R2 R3 lowest prio, lowest id", 5, 4);

    // R4 disabled ones drop out without blocking
    wr(SEL_ENABLE, 5, 0); idle(2);
    fwd_is("R4 individual disable", 9, 4);
    wr(SEL_GROUP, 9, 1); wr(SEL_GRPEN, 0, 1); idle(2);
    fwd_is("R4 group disable", 3, 10);

    // R5 pending latches with groups off
    do_reset();
    cfg(4, 6); wr(SEL_TRIG, 4, 1);
    @(negedge clk_i); src_i[4] = 1'b1;
    @(negedge clk_i); src_i[4] = 1'b0;
    idle(3);
    chk("R5 no fwd while group off", int'(fwd_valid_o), 0);
    wr(SEL_GRPEN, 0, 1); idle(2);
    fwd_is("R5 latched pending", 4, 6);

    // R6 acknowledge
    ack_exp(4, "R6 ack id");
    chk("R6 fwd empty after ack", int'(fwd_valid_o), 0);
    chk("R9 running after ack", int'(running_prio_o), 6);

    // R7 re-pend while active
    @(negedge clk_i); src_i[4] = 1'b1;
    @(negedge clk_i); src_i[4] = 1'b0;
    idle(3);
    chk("R7 active not reforwarded", int'(fwd_valid_o), 0);
    eoi(4); idle(2);
    chk("R8 running idle after eoi", int'(running_prio_o), IDLE);
    fwd_is("R8 reforward after eoi", 4, 6);

    // R5 edge held high pends once, level re-pends
    do_reset();
    wr(SEL_GRPEN, 0, 1); cfg(4, 6); wr(SEL_TRIG, 4, 1);
    @(negedge clk_i); src_i[4] = 1'b1;
    idle(3);
    ack_exp(4, "R5 edge ack");
    eoi(4); idle(3);
    chk("R5 edge held pends once", int'(fwd_valid_o), 0);
    wr(SEL_TRIG, 4, 0); idle(3);
    fwd_is("R5 level re-pends", 4, 6);

    // R9 running priority gate
    do_reset();
    wr(SEL_GRPEN, 0, 1); cfg(4, 6);
    @(negedge clk_i); src_i[4] = 1'b1;
    idle(3);
    ack_exp(4, "R9 ack");
    cfg(8, 7); cfg(11, 6);
    @(negedge clk_i); src_i[8] = 1'b1; src_i[11] = 1'b1;
    idle(3);
    chk("R9 equal or worse blocked", int'(fwd_valid_o), 0);
    cfg(1, 5);
    @(negedge clk_i); src_i[1] = 1'b1;
    idle(3);
    fwd_is("R9 more urgent passes", 1, 5);

    // R10 recall
    do_reset();
    wr(SEL_GRPEN, 0, 1); cfg(6, 8); cfg(10, 9);
    @(negedge clk_i); src_i[6] = 1'b1; src_i[10] = 1'b1;
    idle(3);
    fwd_is("R10 before rewrite", 6, 8);
    wr(SEL_PRIO, 6, 12); idle(2);
    chk("R10 recall count", rec_cnt, 1);
    chk("R10 recall id", rec_last, 6);
    fwd_is("R10 reselect", 10, 9);

    // R11 rewrite of active
    ack_exp(10, "R11 ack");
    wr(SEL_PRIO, 10, 2); idle(3);
    chk("R11 running kept", int'(running_prio_o), 9);
    chk("R11 no recall", rec_cnt, 1);
    chk("R11 blocked by running", int'(fwd_valid_o), 0);
    eoi(10); idle(3);
    fwd_is("R11 new prio next instance", 10, 2);

    // R12 coarse class
    do_reset();
    wr(SEL_GRPEN, 0, 1); cfg(28, 7); cfg(20, 7);
    @(negedge clk_i); src_i[28] = 1'b1; src_i[20] = 1'b1;
    idle(3);
    fwd_is("R12 lsb dropped", 28, 6);
    wr(SEL_PRIO, 28, 9); idle(3);
    fwd_is("R12 9 stored as 8", 20, 7);

    // R13 spurious
    do_reset();
    ack_exp(SPUR, "R13 spurious id");
    idle(1);
    chk("R13 running unchanged", int'(running_prio_o), IDLE);
    chk("R13 nothing forwarded", int'(fwd_valid_o), 0);

    // R14 ack and rewrite together
    do_reset();
    wr(SEL_GRPEN, 0, 1); cfg(6, 8);
    @(negedge clk_i); src_i[6] = 1'b1;
    idle(3);
    @(negedge clk_i);
    ack_i = 1'b1; reg_we_i = 1'b1; reg_sel_i = SEL_PRIO; reg_id_i = 6; reg_wdata_i = 3;
    #1ns;
    ack_exp_q.push_back(6); ack_tag_q.push_back("R14 ack id");
    ack_act_q.push_back(int'(ack_id_o));
    @(negedge clk_i);
    ack_i = 1'b0; reg_we_i = 1'b0;
    idle(2);
    chk("R14 no recall", rec_cnt, 0);
    chk("R14 old prio active", int'(running_prio_o), 8);

    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule